// File: doc/BRIEF.md
# Socket Activity LED Stretcher

This block turns the bus activity of two card sockets into indicator-lamp signals that a person can see. Each socket's raw activity is qualified by the socket's state and by the kind of card in it, and every qualified activity sample starts a hold timer that keeps that socket's lamp lit for a fixed time. The default time is 64 ms at a 33 MHz counting clock. Any new activity restarts the timer, so a socket that is busy at least once per window shows a steady light. A third lamp output is lit whenever either socket's lamp would be lit.

A card counts as active only when it is present, powered and out of reset. A 16-bit card signals activity by pulling its ready/interrupt line low. A 32-bit bus-mastering card signals activity when it drives its frame, initiator-ready or bus-request line. Suspend, a pending clock stop and the low-power states D1 and D2 all turn every lamp off at once. They also clear the timers, so a lamp cannot come back on by itself when the cut-off ends.

The hold length is a parameter derived from the clock frequency and the hold time in milliseconds. A test run can therefore use a short window. All inputs are synchronous to the counting clock and are sampled on every rising edge.

Top module: `socket_activity_leds`

## Requirements
- R1: While `rst` is high at a rising edge, every timer is cleared. After that edge every LED output is low, whatever the activity inputs do.
- R2: A qualified activity sample at a rising edge makes the socket's LED high right after that edge. With no further activity, the LED stays high for exactly HOLD_CYCLES edges and drops after the HOLD_CYCLES-th edge that follows the activity edge. HOLD_CYCLES defaults to CLK_HZ/1000*HOLD_MS, which is 2,112,000 at 33 MHz and 64 ms.
- R3: Activity while a window is running restarts the full HOLD_CYCLES window. Activity at least once every HOLD_CYCLES edges therefore keeps the LED continuously high.
- R4: Activity on a socket counts only when `sock_present`, `sock_powered` are 1 and `sock_in_reset` is 0 for that socket. Otherwise its lines have no effect.
- R5: When `sock_is_cb`=0 (16-bit card), activity is `rdy_irq_n` low. On such a socket, `cb_frame`, `cb_irdy` and `cb_req` have no effect.
- R6: When `sock_is_cb`=1, activity is any of `cb_frame`, `cb_irdy` or `cb_req` high. On such a socket, `rdy_irq_n` has no effect.
- R7: `led_sock[i]` belongs to socket i alone. `led_any` is high exactly when a qualified activity on either socket lies within its hold window.
- R8: While `suspend` is 1, or `clk_stop_pend` is 1, or `pwr_state` is 1 (D1) or 2 (D2), all LED outputs are low in the same cycle.
- R9: A cut-off clears all timers at each edge it is present, and activity during the cut-off is ignored. After the cut-off ends, the LEDs stay low until new qualified activity arrives.
- R10: `pwr_state` values 0 (D0) and 3 (D3) do not cut off the LEDs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Counting clock |
| rst | input | 1 | Synchronous active-high reset |
| sock_present | input | 2 | Card inserted, one bit per socket |
| sock_powered | input | 2 | Socket power on, one bit per socket |
| sock_in_reset | input | 2 | Card held in reset, one bit per socket |
| sock_is_cb | input | 2 | 1 = 32-bit bus card, 0 = 16-bit card |
| rdy_irq_n | input | 2 | 16-bit card ready/interrupt line, low = activity |
| cb_frame | input | 2 | 32-bit card frame asserted (active high here) |
| cb_irdy | input | 2 | 32-bit card initiator-ready asserted |
| cb_req | input | 2 | 32-bit card bus request asserted |
| suspend | input | 1 | System suspend, cuts off all LEDs |
| clk_stop_pend | input | 1 | Clock about to be stopped, cuts off all LEDs |
| pwr_state | input | 2 | Device power state 0..3 = D0..D3 |
| led_sock | output | 2 | Per-socket activity LED, active high |
| led_any | output | 1 | LED for activity on either socket |

## Verification
The bench works the window edges. It checks that a single pulse lights the lamp for exactly HOLD_CYCLES cycles; a design off by one would hold one cycle too long or drop one cycle early. It retriggers just before expiry to catch a timer that only loads from zero, and so lets the lamp flicker. It drives the line of the wrong card kind, and a socket that is absent, unpowered or held in reset, to catch qualification that ignores the card type or the socket state. Each cut-off source is asserted in the middle of a window and then released with no new activity: a design that only masks the output would light the lamp again, and one that decodes D3 as low power would darken it wrongly.

// File: rtl/actled_pkg.sv
package actled_pkg;

    typedef enum logic {
        KIND_16BIT   = 1'b0,
        KIND_CARDBUS = 1'b1
    } card_kind_e;

    typedef enum logic [1:0] {
        PS_D0 = 2'd0,
        PS_D1 = 2'd1,
        PS_D2 = 2'd2,
        PS_D3 = 2'd3
    } pstate_e;

    typedef struct packed {
        logic       present;
        logic       powered;
        logic       held_reset;
        card_kind_e kind;
        logic       ready_irq_n;
        logic       frame;
        logic       irdy;
        logic       req;
    } sock_view_t;

    function automatic int unsigned calc_hold(input int unsigned clk_hz,
                                              input int unsigned ms);
        return (clk_hz / 1000) * ms;
    endfunction

    function automatic logic is_dozing(input pstate_e ps);
        return (ps == PS_D1) || (ps == PS_D2);
    endfunction

endpackage

// File: rtl/actled_qual.sv
module actled_qual
    import actled_pkg::*;
(
    input  sock_view_t view,
    output logic       act_o
);
    logic usable;
    logic raw;

    always_comb begin
        usable = view.present && view.powered && !view.held_reset;
        if (view.kind == KIND_CARDBUS)
            raw = view.frame || view.irdy || view.req;
        else
            raw = !view.ready_irq_n;
        act_o = usable && raw;
    end
endmodule

// File: rtl/actled_cutoff.sv
module actled_cutoff
    import actled_pkg::*;
(
    input  logic    suspend,
    input  logic    clk_stop_pend,
    input  pstate_e ps,
    output logic    kill_o
);
    always_comb kill_o = suspend || clk_stop_pend || is_dozing(ps);
endmodule

// File: rtl/actled_timer.sv
module actled_timer #(
    parameter int unsigned HOLD_CYCLES = 16,
    localparam int unsigned CNT_W = $clog2(HOLD_CYCLES + 1)
) (
    input  logic clk,
    input  logic rst,
    input  logic act_i,
    input  logic kill_i,
    output logic led_o
);
    localparam logic [CNT_W-1:0] LOAD = CNT_W'(HOLD_CYCLES);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || kill_i)
            cnt_q <= '0;
        else if (act_i)
            cnt_q <= LOAD;
        else if (cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    assign led_o = (cnt_q != '0) && !kill_i;

    // R3
    reload_chk: assert property (@(posedge clk) disable iff (rst)
        (act_i && !kill_i) |=> (cnt_q == LOAD));

    // R2
    countdown_chk: assert property (@(posedge clk) disable iff (rst)
        (!act_i && !kill_i && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));

    // R9
    kill_clear_chk: assert property (@(posedge clk) disable iff (rst)
        kill_i |=> (cnt_q == '0));

    // R2
    no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= LOAD);
endmodule

// File: rtl/socket_activity_leds.sv
module socket_activity_leds
    import actled_pkg::*;
#(
    parameter int unsigned NUM_SOCK    = 2,
    parameter int unsigned CLK_HZ      = 33_000_000,
    parameter int unsigned HOLD_MS     = 64,
    parameter int unsigned HOLD_CYCLES = calc_hold(CLK_HZ, HOLD_MS)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [NUM_SOCK-1:0] sock_present,
    input  logic [NUM_SOCK-1:0] sock_powered,
    input  logic [NUM_SOCK-1:0] sock_in_reset,
    input  logic [NUM_SOCK-1:0] sock_is_cb,
    input  logic [NUM_SOCK-1:0] rdy_irq_n,
    input  logic [NUM_SOCK-1:0] cb_frame,
    input  logic [NUM_SOCK-1:0] cb_irdy,
    input  logic [NUM_SOCK-1:0] cb_req,
    input  logic                suspend,
    input  logic                clk_stop_pend,
    input  logic [1:0]          pwr_state,
    output logic [NUM_SOCK-1:0] led_sock,
    output logic                led_any
);
    localparam int unsigned NUM_CH = NUM_SOCK + 1;

    logic [NUM_SOCK-1:0] sock_act;
    logic [NUM_CH-1:0]   ch_act;
    logic [NUM_CH-1:0]   ch_led;
    logic                kill;

    actled_cutoff u_cutoff (
        .suspend       (suspend),
        .clk_stop_pend (clk_stop_pend),
        .ps            (pstate_e'(pwr_state)),
        .kill_o        (kill)
    );

    for (genvar s = 0; s < NUM_SOCK; s++) begin : g_sock
        sock_view_t view;
        always_comb begin
            view.present     = sock_present[s];
            view.powered     = sock_powered[s];
            view.held_reset  = sock_in_reset[s];
            view.kind        = card_kind_e'(sock_is_cb[s]);
            view.ready_irq_n = rdy_irq_n[s];
            view.frame       = cb_frame[s];
            view.irdy        = cb_irdy[s];
            view.req         = cb_req[s];
        end
        actled_qual u_qual (
            .view  (view),
            .act_o (sock_act[s])
        );
    end

    assign ch_act = {|sock_act, sock_act};

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        actled_timer #(.HOLD_CYCLES(HOLD_CYCLES)) u_timer (
            .clk    (clk),
            .rst    (rst),
            .act_i  (ch_act[c]),
            .kill_i (kill),
            .led_o  (ch_led[c])
        );
    end

    assign led_sock = ch_led[NUM_SOCK-1:0];
    assign led_any  = ch_led[NUM_SOCK];

    // R7
    any_match_chk: assert property (@(posedge clk) disable iff (rst)
        led_any == (|led_sock));

    // R8
    cutoff_dark_chk: assert property (@(posedge clk) disable iff (rst)
        (suspend || clk_stop_pend) |-> (led_sock == '0 && !led_any));
endmodule

// File: tb/tb_socket_activity_leds.sv
module tb_socket_activity_leds;
    localparam int H = 16;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [1:0] sock_present = '0, sock_powered = '0, sock_in_reset = '0, sock_is_cb = '0;
    logic [1:0] rdy_irq_n = 2'b11, cb_frame = '0, cb_irdy = '0, cb_req = '0;
    logic       suspend = 1'b0, clk_stop_pend = 1'b0;
    logic [1:0] pwr_state = 2'd0;
    logic [1:0] led_sock;
    logic       led_any;

    int compared = 0;
    int mismatched = 0;
    bit done = 1'b0;

    typedef struct {
        logic [1:0] sock;
        logic       any;
        string      tag;
    } exp_t;
    exp_t q[$];

    int mcnt[3] = '{0, 0, 0};

    always #10 clk = ~clk;

    socket_activity_leds #(.HOLD_CYCLES(H)) dut (
        .clk(clk), .rst(rst),
        .sock_present(sock_present), .sock_powered(sock_powered),
        .sock_in_reset(sock_in_reset), .sock_is_cb(sock_is_cb),
        .rdy_irq_n(rdy_irq_n), .cb_frame(cb_frame), .cb_irdy(cb_irdy),
        .cb_req(cb_req), .suspend(suspend), .clk_stop_pend(clk_stop_pend),
        .pwr_state(pwr_state), .led_sock(led_sock), .led_any(led_any)
    );

    function automatic logic model_act(int s);
        logic ok;
        ok = sock_present[s] && sock_powered[s] && !sock_in_reset[s];
        if (sock_is_cb[s]) return ok && (cb_frame[s] || cb_irdy[s] || cb_req[s]);
        return ok && !rdy_irq_n[s];
    endfunction

    // Driver: runs n cycles with the current inputs, pushing expectations.
    task automatic tick(int n, string tag);
        for (int k = 0; k < n; k++) begin
            logic a[3];
            logic kill;
            exp_t e;
            a[0] = model_act(0);
            a[1] = model_act(1);
            a[2] = a[0] || a[1];
            kill = suspend || clk_stop_pend || pwr_state == 2'd1 || pwr_state == 2'd2;
            for (int c = 0; c < 3; c++) begin
                if (rst || kill) mcnt[c] = 0;
                else if (a[c]) mcnt[c] = H;
                else if (mcnt[c] > 0) mcnt[c] = mcnt[c] - 1;
            end
            e.sock[0] = (mcnt[0] != 0) && !kill;
            e.sock[1] = (mcnt[1] != 0) && !kill;
            e.any     = (mcnt[2] != 0) && !kill;
            e.tag     = tag;
            q.push_back(e);
            @(negedge clk);
        end
    endtask

    // Monitor
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (q.size() > 0) begin
                exp_t e;
                e = q.pop_front();
                compared++;
                if (led_sock !== e.sock || led_any !== e.any) begin
                    mismatched++;
                    $display("FAIL %s: led_sock=%b led_any=%b expected led_sock=%b led_any=%b",
                             e.tag, led_sock, led_any, e.sock, e.any);
                end
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            mismatched++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        // R1: reset dominates activity
        sock_present = 2'b11; sock_powered = 2'b11; rdy_irq_n = 2'b00;
        tick(3, "R1");
        rdy_irq_n = 2'b11;
        rst = 1'b0;
        tick(2, "R1");

        // R2 + R5: single pulse on 16-bit socket 0, exact window length
        rdy_irq_n[0] = 1'b0; tick(1, "R2");
        rdy_irq_n[0] = 1'b1; tick(H + 3, "R2");

        // R5: bus-card lines on a 16-bit socket ignored
        cb_frame[0] = 1'b1; cb_irdy[0] = 1'b1; cb_req[0] = 1'b1;
        tick(4, "R5");
        cb_frame[0] = 1'b0; cb_irdy[0] = 1'b0; cb_req[0] = 1'b0;

        // R6: 32-bit card on socket 1, each line, rdy_irq_n ignored
        sock_is_cb[1] = 1'b1;
        rdy_irq_n[1] = 1'b0; tick(4, "R6");
        rdy_irq_n[1] = 1'b1;
        cb_frame[1] = 1'b1; tick(1, "R6"); cb_frame[1] = 1'b0; tick(H + 2, "R6");
        cb_irdy[1] = 1'b1;  tick(1, "R6"); cb_irdy[1] = 1'b0;  tick(H + 2, "R6");
        cb_req[1] = 1'b1;   tick(1, "R6"); cb_req[1] = 1'b0;   tick(H + 2, "R6");

        // R3: retrigger just before expiry keeps LED solid
        for (int i = 0; i < 5; i++) begin
            rdy_irq_n[0] = 1'b0; tick(1, "R3");
            rdy_irq_n[0] = 1'b1; tick(H - 1, "R3");
        end
        tick(3, "R3");

        // R4: absent, unpowered, held in reset
        sock_present[0] = 1'b0; rdy_irq_n[0] = 1'b0; tick(3, "R4");
        sock_present[0] = 1'b1; sock_powered[0] = 1'b0; tick(3, "R4");
        sock_powered[0] = 1'b1; sock_in_reset[0] = 1'b1; tick(3, "R4");
        sock_in_reset[0] = 1'b0; rdy_irq_n[0] = 1'b1; tick(2, "R4");

        // R7: staggered activity on both sockets
        rdy_irq_n[0] = 1'b0; tick(1, "R7"); rdy_irq_n[0] = 1'b1; tick(6, "R7");
        cb_req[1] = 1'b1; tick(1, "R7"); cb_req[1] = 1'b0; tick(H + 4, "R7");

        // R8 / R9: each cut-off mid-window, then released with no activity
        for (int src = 0; src < 4; src++) begin
            rdy_irq_n[0] = 1'b0; cb_frame[1] = 1'b1; tick(1, "R8");
            rdy_irq_n[0] = 1'b1; cb_frame[1] = 1'b0; tick(4, "R8");
            case (src)
                0: suspend = 1'b1;
                1: clk_stop_pend = 1'b1;
                2: pwr_state = 2'd1;
                default: pwr_state = 2'd2;
            endcase
            tick(2, "R8");
            rdy_irq_n[0] = 1'b0; tick(2, "R9");
            rdy_irq_n[0] = 1'b1;
            suspend = 1'b0; clk_stop_pend = 1'b0; pwr_state = 2'd0;
            tick(H + 2, "R9");
        end

        // R10: D0 and D3 keep LEDs working
        pwr_state = 2'd3;
        rdy_irq_n[0] = 1'b0; tick(1, "R10"); rdy_irq_n[0] = 1'b1; tick(H + 2, "R10");
        pwr_state = 2'd0;
        cb_irdy[1] = 1'b1; tick(1, "R10"); cb_irdy[1] = 1'b0; tick(H + 2, "R10");

        tick(2, "R1");
        @(posedge clk); #2;
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule